// File: doc/BRIEF.md
# Trap entry unit

The trap entry unit performs the architectural state update that a small 32-bit RISC core makes when it enters an exception. The core asserts a one-cycle take strobe. With it the core presents the current program counter, a flag that marks an instruction in a branch delay slot, the requested exception cause, the current status and power-management words, the vector base register and a capability bit that enables a programmable base. Two pending interrupt lines, tick and external, are sampled at the same strobe.

In that cycle the unit decides which cause is served. An eligible interrupt wins over the requested cause, and tick wins over external. The unit then registers the saved PC, the saved status, the new status, the new power-management word, the vector PC and, for illegal instructions, the error address. It pulses a taken flag for one cycle. A cause outside the implemented range produces a one-cycle error pulse instead, and no state changes. The unit also holds the load-link reservation address, which every entry invalidates.

Top module: `trap_entry`

## Requirements
- R1: After reset, taken_o, err_o and eear_we_o are 0, the reservation address is all ones, and epc_o, esr_o, sr_o, pm_o, vec_o, eear_o and cause_o are 0.
- R2: At a strobe, a tick interrupt is eligible only when status bit 1 is set, and an external interrupt only when status bit 2 is set. The served cause is 5 when the tick is eligible, otherwise 8 when the external one is eligible, otherwise cause_i. The served cause appears on cause_o.
- R3: Only served causes from 1 to N_CAUSE-1 (1..14 by default) are valid. Any other value pulses err_o for one cycle, leaves taken_o low and leaves every held output unchanged.
- R4: The saved PC is pc_i, minus 4 when dslot_i is set. For cause 12 (system call), 4 is then added to it.
- R5: For cause 7 (illegal instruction), eear_o is loaded with pc_i and eear_we_o pulses. For every other cause, eear_o keeps its value and eear_we_o stays 0.
- R6: esr_o receives the unmodified sr_i that was present at the strobe.
- R7: The new status is sr_i with bit 0 (supervisor) set and bits 1 (tick enable), 2 (interrupt enable), 5 (data translation) and 6 (instruction translation) cleared. Bit 13 (delay-slot exception) equals dslot_i. All other bits are kept.
- R8: The new power-management word is pm_i with bits 4 (doze enable) and 5 (sleep enable) cleared and all other bits kept.
- R9: The vector PC is the served cause shifted left by 8. It is OR-ed with base_i when base_en_i is set, and with 0xF0000000 when sr_i bit 14 (high vectors) is set.
- R10: resv_set_i loads resv_addr_i into the reservation address. A valid entry sets the address to all ones and wins over a simultaneous load.
- R11: All results appear on the clock edge that samples the strobe. taken_o is high for exactly that one cycle, and the held outputs stay stable while no entry is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | One-cycle strobe requesting exception entry |
| cause_i | input | 4 | Requested exception cause |
| pc_i | input | 32 | Current program counter |
| dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| sr_i | input | 32 | Current status register |
| pm_i | input | 32 | Current power-management register |
| base_i | input | 32 | Vector base register |
| base_en_i | input | 1 | Capability bit enabling the programmable base |
| irq_ext_i | input | 1 | Pending external interrupt |
| irq_tick_i | input | 1 | Pending tick-timer interrupt |
| resv_set_i | input | 1 | Load a new reservation address |
| resv_addr_i | input | 32 | Reservation address to load |
| taken_o | output | 1 | One-cycle pulse: entry performed |
| err_o | output | 1 | One-cycle pulse: unserviceable cause |
| cause_o | output | 4 | Cause that was served |
| epc_o | output | 32 | Saved exception PC |
| esr_o | output | 32 | Saved status register |
| sr_o | output | 32 | New status register |
| pm_o | output | 32 | New power-management register |
| vec_o | output | 32 | Vector PC |
| eear_o | output | 32 | Error effective address |
| eear_we_o | output | 1 | Pulse: error address updated |
| resv_addr_o | output | 32 | Load-link reservation address |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 15 causes and an 8-bit vector shift. With 15 causes the cause field is four bits wide, so the largest encodable index, 15, is exactly the first invalid one, and both ends of the invalid range (0 and 15) can be driven. The 8-bit shift keeps the shifted cause clear of the base and prefix bits, so every OR combination of the vector can be told apart.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // status word bit positions
  localparam int SB_SUPER    = 0;
  localparam int SB_TICK_EN  = 1;
  localparam int SB_IRQ_EN   = 2;
  localparam int SB_DMMU_EN  = 5;
  localparam int SB_IMMU_EN  = 6;
  localparam int SB_DSLOT    = 13;
  localparam int SB_HIVEC    = 14;
  // power-management bit positions
  localparam int PB_DOZE     = 4;
  localparam int PB_SLEEP    = 5;
  // cause codes
  localparam int CAUSE_TICK    = 5;
  localparam int CAUSE_ILLEGAL = 7;
  localparam int CAUSE_EXT     = 8;
  localparam int CAUSE_SYSCALL = 12;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int N_CAUSE = 15,
  parameter int IDX_W   = 4
) (
  input  logic             take,
  input  logic [IDX_W-1:0] cause_req,
  input  logic             irq_ext,
  input  logic             irq_tick,
  input  logic             tick_en,
  input  logic             irq_en,
  output logic [IDX_W-1:0] cause_sel,
  output logic             fire,
  output logic             fault
);
  logic tick_ok, ext_ok, in_range;

  always_comb begin
    tick_ok = irq_tick && tick_en;
    ext_ok  = irq_ext && irq_en;
    if (tick_ok)
      cause_sel = IDX_W'(CAUSE_TICK);
    else if (ext_ok)
      cause_sel = IDX_W'(CAUSE_EXT);
    else
      cause_sel = cause_req;
    in_range = (cause_sel != '0) && (int'(cause_sel) < N_CAUSE);
    fire  = take && in_range;
    fault = take && !in_range;
  end
endmodule

// File: rtl/trap_frame.sv
module trap_frame
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic             dslot,
  input  logic [IDX_W-1:0] cause,
  input  logic [XLEN-1:0]  sr,
  input  logic [XLEN-1:0]  pm,
  output logic [XLEN-1:0]  epc,
  output logic [XLEN-1:0]  sr_new,
  output logic [XLEN-1:0]  pm_new,
  output logic             is_illegal
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_ds;

  always_comb begin
    pc_ds = dslot ? (pc - STEP) : pc;
    epc   = (cause == IDX_W'(CAUSE_SYSCALL)) ? (pc_ds + STEP) : pc_ds;
    is_illegal = (cause == IDX_W'(CAUSE_ILLEGAL));

    sr_new = sr;
    sr_new[SB_SUPER]   = 1'b1;
    sr_new[SB_TICK_EN] = 1'b0;
    sr_new[SB_IRQ_EN]  = 1'b0;
    sr_new[SB_DMMU_EN] = 1'b0;
    sr_new[SB_IMMU_EN] = 1'b0;
    sr_new[SB_DSLOT]   = dslot;

    pm_new = pm;
    pm_new[PB_DOZE]  = 1'b0;
    pm_new[PB_SLEEP] = 1'b0;
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int              XLEN      = 32,
  parameter int              IDX_W     = 4,
  parameter int              VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HI_PREFIX = 32'hF000_0000
) (
  input  logic [IDX_W-1:0] cause,
  input  logic [XLEN-1:0]  base,
  input  logic             base_en,
  input  logic             hivec,
  output logic [XLEN-1:0]  vec
);
  always_comb begin
    vec = XLEN'(cause) << VEC_SHIFT;
    if (base_en) vec = vec | base;
    if (hivec)   vec = vec | HI_PREFIX;
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              N_CAUSE   = 15,
  parameter int              VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HI_PREFIX = {4'hF, {(XLEN-4){1'b0}}},
  localparam int             IDX_W     = $clog2(N_CAUSE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic [IDX_W-1:0] cause_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             dslot_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  pm_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic             base_en_i,
  input  logic             irq_ext_i,
  input  logic             irq_tick_i,
  input  logic             resv_set_i,
  input  logic [XLEN-1:0]  resv_addr_i,
  output logic             taken_o,
  output logic             err_o,
  output logic [IDX_W-1:0] cause_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  esr_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  pm_o,
  output logic [XLEN-1:0]  vec_o,
  output logic [XLEN-1:0]  eear_o,
  output logic             eear_we_o,
  output logic [XLEN-1:0]  resv_addr_o
);
  logic [IDX_W-1:0] cause_sel;
  logic             fire, fault, is_illegal;
  logic [XLEN-1:0]  epc_n, sr_n, pm_n, vec_n;

  trap_select #(.N_CAUSE(N_CAUSE), .IDX_W(IDX_W)) u_sel (
    .take      (take_i),
    .cause_req (cause_i),
    .irq_ext   (irq_ext_i),
    .irq_tick  (irq_tick_i),
    .tick_en   (sr_i[SB_TICK_EN]),
    .irq_en    (sr_i[SB_IRQ_EN]),
    .cause_sel (cause_sel),
    .fire      (fire),
    .fault     (fault)
  );

  trap_frame #(.XLEN(XLEN), .IDX_W(IDX_W)) u_frame (
    .pc         (pc_i),
    .dslot      (dslot_i),
    .cause      (cause_sel),
    .sr         (sr_i),
    .pm         (pm_i),
    .epc        (epc_n),
    .sr_new     (sr_n),
    .pm_new     (pm_n),
    .is_illegal (is_illegal)
  );

  trap_vector #(.XLEN(XLEN), .IDX_W(IDX_W), .VEC_SHIFT(VEC_SHIFT),
                .HI_PREFIX(HI_PREFIX)) u_vec (
    .cause   (cause_sel),
    .base    (base_i),
    .base_en (base_en_i),
    .hivec   (sr_i[SB_HIVEC]),
    .vec     (vec_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o     <= 1'b0;
      err_o       <= 1'b0;
      eear_we_o   <= 1'b0;
      cause_o     <= '0;
      epc_o       <= '0;
      esr_o       <= '0;
      sr_o        <= '0;
      pm_o        <= '0;
      vec_o       <= '0;
      eear_o      <= '0;
      resv_addr_o <= '1;
    end else begin
      taken_o   <= fire;
      err_o     <= fault;
      eear_we_o <= fire && is_illegal;
      if (fire) begin
        cause_o <= cause_sel;
        epc_o   <= epc_n;
        esr_o   <= sr_i;
        sr_o    <= sr_n;
        pm_o    <= pm_n;
        vec_o   <= vec_n;
        if (is_illegal) eear_o <= pc_i;
      end
      if (fire)
        resv_addr_o <= '1;
      else if (resv_set_i)
        resv_addr_o <= resv_addr_i;
    end
  end

  // R11: the taken pulse follows a strobe and lasts one cycle
  p_taken_follows_r11: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> $past(take_i));
  p_held_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> ($stable(epc_o) && $stable(sr_o) && $stable(vec_o)));
  // R3: an error never coincides with an entry and changes nothing
  p_err_no_update_r3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!taken_o && $stable(esr_o) && $stable(pm_o)));
  // R2: an enabled tick always wins
  p_tick_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (taken_o && $past(irq_tick_i && sr_i[SB_TICK_EN]))
      |-> (cause_o == IDX_W'(CAUSE_TICK)));
  // R4: non-syscall saved PC is corrected only by the delay slot
  p_epc_r4: assert property (@(posedge clk) disable iff (rst)
    (taken_o && cause_o != IDX_W'(CAUSE_SYSCALL))
      |-> (epc_o == ($past(pc_i) - ($past(dslot_i) ? XLEN'(4) : XLEN'(0)))));
  // R6: saved status is the pre-entry word
  p_esr_r6: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (esr_o == $past(sr_i)));
  // R7: supervisor on, interrupts off, delay-slot bit tracks the flag
  p_sr_r7: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (sr_o[SB_SUPER] && !sr_o[SB_IRQ_EN] && !sr_o[SB_TICK_EN]
                 && (sr_o[SB_DSLOT] == $past(dslot_i))));
  // R5: the error address only moves on illegal-instruction entry
  p_eear_r5: assert property (@(posedge clk) disable iff (rst)
    !eear_we_o |-> $stable(eear_o));
  // R10: every entry kills the reservation
  p_resv_r10: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (resv_addr_o == '1));
endmodule

// File: tb/trap_entry_test.sv
module trap_entry_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        take_i = 1'b0;
  logic [3:0]  cause_i = '0;
  logic [31:0] pc_i = '0, sr_i = '0, pm_i = '0, base_i = '0, resv_addr_i = '0;
  logic        dslot_i = 1'b0, base_en_i = 1'b0;
  logic        irq_ext_i = 1'b0, irq_tick_i = 1'b0, resv_set_i = 1'b0;
  logic        taken_o, err_o, eear_we_o;
  logic [3:0]  cause_o;
  logic [31:0] epc_o, esr_o, sr_o, pm_o, vec_o, eear_o, resv_addr_o;

  int tests = 0;
  int fails = 0;

  // bench-side model of held outputs
  logic [31:0] m_epc, m_esr, m_sr, m_pm, m_vec, m_eear;
  logic [3:0]  m_cause;

  always #10 clk = ~clk;

  trap_entry uut (
    .clk(clk), .rst(rst), .take_i(take_i), .cause_i(cause_i), .pc_i(pc_i),
    .dslot_i(dslot_i), .sr_i(sr_i), .pm_i(pm_i), .base_i(base_i),
    .base_en_i(base_en_i), .irq_ext_i(irq_ext_i), .irq_tick_i(irq_tick_i),
    .resv_set_i(resv_set_i), .resv_addr_i(resv_addr_i),
    .taken_o(taken_o), .err_o(err_o), .cause_o(cause_o), .epc_o(epc_o),
    .esr_o(esr_o), .sr_o(sr_o), .pm_o(pm_o), .vec_o(vec_o), .eear_o(eear_o),
    .eear_we_o(eear_we_o), .resv_addr_o(resv_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one strobe with full checking against the requirement model
  task automatic entry(input logic [3:0] c, input logic [31:0] pc, input logic ds,
                       input logic [31:0] sr, input logic [31:0] base, input logic ben,
                       input logic ext, input logic tick, input logic [31:0] pm);
    logic [3:0]  ec;
    logic        ok;
    logic [31:0] e;
    @(negedge clk);
    cause_i = c; pc_i = pc; dslot_i = ds; sr_i = sr; base_i = base;
    base_en_i = ben; irq_ext_i = ext; irq_tick_i = tick; pm_i = pm; take_i = 1'b1;
    // R2 selection
    if (tick && sr[1]) ec = 4'd5;
    else if (ext && sr[2]) ec = 4'd8;
    else ec = c;
    ok = (ec != 4'd0) && (ec < 4'd15);
    @(posedge clk);
    @(negedge clk);
    take_i = 1'b0; irq_ext_i = 1'b0; irq_tick_i = 1'b0;
    chk("R11 taken pulse", {31'b0, taken_o}, {31'b0, ok});
    chk("R3 error pulse", {31'b0, err_o}, {31'b0, !ok});
    if (ok) begin
      m_cause = ec;
      e = pc - (ds ? 32'd4 : 32'd0);
      if (ec == 4'd12) e = e + 32'd4;
      m_epc = e;
      m_esr = sr;
      m_sr  = (sr & ~32'h0000_2067) | 32'h1 | (ds ? 32'h2000 : 32'h0);
      m_pm  = pm & ~32'h30;
      m_vec = ({28'b0, ec} << 8) | (ben ? base : 32'h0) | (sr[14] ? 32'hF000_0000 : 32'h0);
      if (ec == 4'd7) m_eear = pc;
    end
    chk("R2 served cause", {28'b0, cause_o}, {28'b0, m_cause});
    chk("R4 saved pc", epc_o, m_epc);
    chk("R6 saved status", esr_o, m_esr);
    chk("R7 new status", sr_o, m_sr);
    chk("R8 power mgmt", pm_o, m_pm);
    chk("R9 vector", vec_o, m_vec);
    chk("R5 error addr", eear_o, m_eear);
    chk("R5 error addr strobe", {31'b0, eear_we_o}, {31'b0, ok && ec == 4'd7});
    if (ok) chk("R10 reservation killed", resv_addr_o, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 taken one cycle", {31'b0, taken_o}, 32'h0);
    chk("R11 error one cycle", {31'b0, err_o}, 32'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 taken", {31'b0, taken_o}, 32'h0);
    chk("R1 err", {31'b0, err_o}, 32'h0);
    chk("R1 eear strobe", {31'b0, eear_we_o}, 32'h0);
    chk("R1 reservation", resv_addr_o, 32'hFFFF_FFFF);
    chk("R1 epc", epc_o, 32'h0);
    chk("R1 sr", sr_o, 32'h0);
    chk("R1 vec", vec_o, 32'h0);
    chk("R1 cause", {28'b0, cause_o}, 32'h0);
    m_epc = 0; m_esr = 0; m_sr = 0; m_pm = 0; m_vec = 0; m_eear = 0; m_cause = 0;
  endtask

  task automatic t_kinds();
    logic [3:0] kinds [6] = '{4'd7, 4'd12, 4'd2, 4'd1, 4'd14, 4'd9};
    for (int k = 0; k < 6; k++) begin
      for (int d = 0; d < 2; d++) begin
        entry(kinds[k], 32'h0000_4000 + 32'(k * 16), d[0], 32'hFFFF_8077 ^ 32'(k),
              32'h0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);
      end
    end
  endtask

  task automatic t_irq();
    entry(4'd2, 32'h100, 1'b0, 32'h6, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0);   // R2 both, tick wins
    entry(4'd2, 32'h104, 1'b0, 32'h4, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0);   // R2 tick masked
    entry(4'd2, 32'h108, 1'b1, 32'h2, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);   // R2 ext masked
    entry(4'd0, 32'h10C, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 32'h0);   // R2 both masked, R3 error
    entry(4'd0, 32'h110, 1'b0, 32'h2, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0);   // R2 tick rescues cause 0
  endtask

  task automatic t_invalid();
    entry(4'd0,  32'hDEAD_0000, 1'b1, 32'h1234_5678, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0); // R3
    entry(4'd15, 32'hBEEF_0000, 1'b0, 32'h8765_4321, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0); // R3
  endtask

  task automatic t_vector();
    for (int v = 0; v < 4; v++) begin   // R9 base / prefix combinations
      entry(4'd3, 32'h2000, 1'b0, v[1] ? 32'h4000 : 32'h0, 32'h0012_0000,
            v[0], 1'b0, 1'b0, 32'h0);
    end
  endtask

  task automatic t_resv();
    @(negedge clk);
    resv_set_i = 1'b1; resv_addr_i = 32'h0000_ABC0;
    @(posedge clk);
    @(negedge clk);
    resv_set_i = 1'b0;
    chk("R10 reservation load", resv_addr_o, 32'h0000_ABC0);
    // entry and load in the same cycle: entry wins
    resv_set_i = 1'b1; resv_addr_i = 32'h0000_1230;
    take_i = 1'b1; cause_i = 4'd6; pc_i = 32'h300; dslot_i = 1'b0; sr_i = 32'h0;
    base_en_i = 1'b0; pm_i = 32'h0;
    @(posedge clk);
    @(negedge clk);
    take_i = 1'b0; resv_set_i = 1'b0;
    chk("R10 entry beats load", resv_addr_o, 32'hFFFF_FFFF);
    m_cause = 4'd6; m_epc = 32'h300; m_esr = 32'h0; m_sr = 32'h1; m_pm = 32'h0;
    m_vec = 32'h600;
  endtask

  task automatic t_hold();
    @(negedge clk);
    pc_i = 32'h7777_0000; sr_i = 32'hFFFF_FFFF; irq_ext_i = 1'b1; irq_tick_i = 1'b1;
    repeat (4) @(negedge clk);
    irq_ext_i = 1'b0; irq_tick_i = 1'b0;
    chk("R11 no strobe no taken", {31'b0, taken_o}, 32'h0);
    chk("R11 epc held", epc_o, m_epc);
    chk("R11 sr held", sr_o, m_sr);
    chk("R11 vec held", vec_o, m_vec);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_kinds();
    t_irq();
    t_invalid();
    t_vector();
    t_resv();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule